// File: doc/BRIEF.md
# Phase-Continuous FSK Transmit Modulator

This block turns a serial NRZ transmit bit into a two-tone frequency-shift-keyed waveform, delivered as a stream of digital sample codes. A downstream DAC or reconstruction filter consumes these codes. The block runs from a 460.8 kHz logic clock. A 16-bit phase accumulator advances each clock by one of two increments. A data bit of 1 (mark) selects an increment that gives about 1200 Hz. A data bit of 0 (space) selects one that gives about 2200 Hz. Switching between tones changes only the increment, so the waveform never jumps in phase.

The most significant bit of the accumulator picks a target level, either the high rail or the low rail. A slew limiter moves the output code toward that target by a fixed step every clock. The step is larger at the space tone, so the output takes a trapezoidal shape whose edges are about 1.8 times steeper at 2200 Hz than at 1200 Hz.

The block transmits only while the active-low request-to-send input is held low. While that input is high, the output code rests at midscale and the accumulator is held at zero, so every burst starts from a known phase. The host is expected to change the data bit once per bit time (384 clocks at 1200 bit/s). The block itself samples the bit on every clock.

Top module: `fsk_tx_mod`

## Requirements
- R1: While rst_n is low, wave_code is 128 and nco_phase is 0.
- R2: On every clock edge at which rts_n is 1, wave_code becomes 128 (midscale), whatever the value of txd.
- R3: On every clock edge at which rts_n is 0, nco_phase increases by 171 when txd is 1 (mark) or by 313 when txd is 0 (space), modulo 65536.
- R4: A change of txd while rts_n stays 0 does not reset or reload nco_phase; the accumulated value carries on and only the increment changes.
- R5: On every clock edge at which rts_n is 1, nco_phase becomes 0, so the next burst starts from phase 0.
- R6: While rts_n is 0, the target level is 192 when bit 15 of nco_phase (before the edge) is 1, and 64 when it is 0; wave_code moves toward that target and never away from it.
- R7: The change of wave_code per active clock is at most 5 when txd is 1 and at most 9 when txd is 0. When the remaining distance to the target is smaller than the step, wave_code lands exactly on the target.
- R8: wave_code always stays within 64 to 192 inclusive.
- R9: txd is sampled on every clock edge; a new txd value selects the increment and the step at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 460.8 kHz logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_n | input | 1 | Active-low request to send; low enables transmission |
| txd | input | 1 | NRZ transmit bit: 1 is mark, 0 is space |
| wave_code | output | 8 | Slew-limited sample code for the external DAC |
| nco_phase | output | 16 | Current phase accumulator value |

## Verification
The bench goes after tone switches in the middle of a burst. A design that reloaded the accumulator on a switch would show a phase step, and its nco_phase would differ from the running sum at once. It exercises ramps that land on a rail with less than a full step left: a shaper without clamping would overshoot to 193 or 196, and one that clamped early would stall short of the rail. It also toggles request-to-send inside a burst and restarts after bursts of every length from 1 to 40 clocks, which catches an accumulator that is not cleared and an idle level that is reached late. Finally, it drives the data bit from a pseudo-random sequence that changes every clock, which catches a design that samples the bit only at tone or rail boundaries.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;

    // Tone chosen by the transmit bit
    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

endpackage

// File: rtl/fsk_tx_tone_sel.sv
module fsk_tx_tone_sel
    import fsk_tx_pkg::*;
(
    input  logic  rts_n,
    input  logic  txd,
    output logic  run,
    output tone_e tone
);

    always_comb begin
        run  = ~rts_n;
        tone = txd ? TONE_MARK : TONE_SPACE;
    end

endmodule

// File: rtl/fsk_tx_nco.sv
module fsk_tx_nco
    import fsk_tx_pkg::*;
#(
    parameter int PHASE_W   = 16,
    parameter int MARK_INC  = 171,
    parameter int SPACE_INC = 313
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  tone_e              tone,
    output logic [PHASE_W-1:0] phase
);

    localparam logic [PHASE_W-1:0] MARK_W  = PHASE_W'(MARK_INC);
    localparam logic [PHASE_W-1:0] SPACE_W = PHASE_W'(SPACE_INC);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } nco_state_t;

    nco_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.acc = '0;
        end else if (tone == TONE_MARK) begin
            st_d.acc = st_q.acc + MARK_W;
        end else begin
            st_d.acc = st_q.acc + SPACE_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.acc;

endmodule

// File: rtl/fsk_tx_shaper.sv
module fsk_tx_shaper
    import fsk_tx_pkg::*;
#(
    parameter int OUT_W      = 8,
    parameter int CODE_LO    = 64,
    parameter int CODE_HI    = 192,
    parameter int CODE_MID   = 128,
    parameter int MARK_STEP  = 5,
    parameter int SPACE_STEP = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             level_hi,
    input  tone_e            tone,
    output logic [OUT_W-1:0] code
);

    localparam logic [OUT_W-1:0] LO_W    = OUT_W'(CODE_LO);
    localparam logic [OUT_W-1:0] HI_W    = OUT_W'(CODE_HI);
    localparam logic [OUT_W-1:0] MID_W   = OUT_W'(CODE_MID);
    localparam logic [OUT_W-1:0] MSTEP_W = OUT_W'(MARK_STEP);
    localparam logic [OUT_W-1:0] SSTEP_W = OUT_W'(SPACE_STEP);

    typedef struct packed {
        logic [OUT_W-1:0] level;
    } shp_state_t;

    shp_state_t st_d, st_q;
    logic [OUT_W-1:0] target;
    logic [OUT_W-1:0] step;
    logic [OUT_W-1:0] gap;

    always_comb begin
        st_d   = st_q;
        target = level_hi ? HI_W : LO_W;
        step   = (tone == TONE_MARK) ? MSTEP_W : SSTEP_W;
        gap    = '0;
        if (!run) begin
            st_d.level = MID_W;
        end else if (st_q.level < target) begin
            gap        = target - st_q.level;
            st_d.level = (gap > step) ? st_q.level + step : target;
        end else begin
            gap        = st_q.level - target;
            st_d.level = (gap > step) ? st_q.level - step : target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= MID_W;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.level;

endmodule

// File: rtl/fsk_tx_mod.sv
module fsk_tx_mod
    import fsk_tx_pkg::*;
#(
    parameter int PHASE_W    = 16,
    parameter int OUT_W      = 8,
    parameter int MARK_INC   = 171,
    parameter int SPACE_INC  = 313,
    parameter int CODE_LO    = 64,
    parameter int CODE_HI    = 192,
    parameter int MARK_STEP  = 5,
    parameter int SPACE_STEP = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rts_n,
    input  logic               txd,
    output logic [OUT_W-1:0]   wave_code,
    output logic [PHASE_W-1:0] nco_phase
);

    localparam int CODE_MID = (CODE_LO + CODE_HI) / 2;

    logic  run;
    tone_e tone;

    fsk_tx_tone_sel u_sel (
        .rts_n (rts_n),
        .txd   (txd),
        .run   (run),
        .tone  (tone)
    );

    fsk_tx_nco #(
        .PHASE_W   (PHASE_W),
        .MARK_INC  (MARK_INC),
        .SPACE_INC (SPACE_INC)
    ) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tone  (tone),
        .phase (nco_phase)
    );

    fsk_tx_shaper #(
        .OUT_W      (OUT_W),
        .CODE_LO    (CODE_LO),
        .CODE_HI    (CODE_HI),
        .CODE_MID   (CODE_MID),
        .MARK_STEP  (MARK_STEP),
        .SPACE_STEP (SPACE_STEP)
    ) u_shp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .level_hi (nco_phase[PHASE_W-1]),
        .tone     (tone),
        .code     (wave_code)
    );

endmodule

// File: rtl/fsk_tx_mod_chk.sv
module fsk_tx_mod_chk #(
    parameter int PHASE_W    = 16,
    parameter int OUT_W      = 8,
    parameter int MARK_INC   = 171,
    parameter int SPACE_INC  = 313,
    parameter int CODE_LO    = 64,
    parameter int CODE_HI    = 192,
    parameter int MARK_STEP  = 5,
    parameter int SPACE_STEP = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rts_n,
    input logic               txd,
    input logic [OUT_W-1:0]   wave_code,
    input logic [PHASE_W-1:0] nco_phase
);

    localparam int CODE_MID = (CODE_LO + CODE_HI) / 2;

    // R2: request-to-send high parks the output at midscale
    p_idle_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n |=> (int'(wave_code) == CODE_MID));

    // R5: request-to-send high clears the accumulator
    p_phase_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n |=> (nco_phase == '0));

    // R3: mark increment
    p_mark_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && txd) |=> (nco_phase == PHASE_W'($past(nco_phase) + PHASE_W'(MARK_INC))));

    // R3: space increment
    p_space_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && !txd) |=> (nco_phase == PHASE_W'($past(nco_phase) + PHASE_W'(SPACE_INC))));

    // R6: upper target never lowers the output
    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && nco_phase[PHASE_W-1]) |=> (wave_code >= $past(wave_code)));

    // R6: lower target never raises the output
    p_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && !nco_phase[PHASE_W-1]) |=> (wave_code <= $past(wave_code)));

    // R7: slope bound at mark
    p_mark_slope_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && txd) |=>
            ((int'(wave_code) - int'($past(wave_code)) <= MARK_STEP) &&
             (int'($past(wave_code)) - int'(wave_code) <= MARK_STEP)));

    // R7: slope bound at space
    p_space_slope_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n && !txd) |=>
            ((int'(wave_code) - int'($past(wave_code)) <= SPACE_STEP) &&
             (int'($past(wave_code)) - int'(wave_code) <= SPACE_STEP)));

    // R8: output within the rails
    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(wave_code) >= CODE_LO) && (int'(wave_code) <= CODE_HI));

endmodule

bind fsk_tx_mod fsk_tx_mod_chk #(
    .PHASE_W    (PHASE_W),
    .OUT_W      (OUT_W),
    .MARK_INC   (MARK_INC),
    .SPACE_INC  (SPACE_INC),
    .CODE_LO    (CODE_LO),
    .CODE_HI    (CODE_HI),
    .MARK_STEP  (MARK_STEP),
    .SPACE_STEP (SPACE_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rts_n     (rts_n),
    .txd       (txd),
    .wave_code (wave_code),
    .nco_phase (nco_phase)
);

// File: tb/fsk_tx_mod_tb.sv
module fsk_tx_mod_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rts_n = 1'b1;
    logic        txd = 1'b1;
    logic [7:0]  wave_code;
    logic [15:0] nco_phase;

    int checks = 0;
    int errors = 0;
    int exp_phase = 0;
    int exp_code = 128;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tx_mod u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts_n     (rts_n),
        .txd       (txd),
        .wave_code (wave_code),
        .nco_phase (nco_phase)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare after it
    task automatic tick(input logic r, input logic b, input string req);
        int tgt;
        int stp;
        @(negedge clk);
        rts_n = r;
        txd   = b;
        @(posedge clk);
        #1;
        if (r) begin
            exp_phase = 0;
            exp_code  = 128;
        end else begin
            tgt = (exp_phase >= 32768) ? 192 : 64;
            stp = b ? 5 : 9;
            if (exp_code < tgt)
                exp_code = (tgt - exp_code > stp) ? exp_code + stp : tgt;
            else
                exp_code = (exp_code - tgt > stp) ? exp_code - stp : tgt;
            exp_phase = (exp_phase + (b ? 171 : 313)) % 65536;
        end
        check(req, "phase", int'(nco_phase), exp_phase);
        check(req, "code", int'(wave_code), exp_code);
        checks++;
        if (wave_code < 8'd64 || wave_code > 8'd192) begin
            errors++;
            $display("FAIL R8 range: actual %0d expected 64..192", wave_code);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset code", int'(wave_code), 128);
        check("R1", "reset phase", int'(nco_phase), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle with the data bit toggling
        for (int i = 0; i < 50; i++) tick(1'b1, i[0], "R2");

        // R3 R6 R7: steady mark, then steady space
        for (int i = 0; i < 800; i++) tick(1'b0, 1'b1, "R3 mark");
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, "R5");
        for (int i = 0; i < 800; i++) tick(1'b0, 1'b0, "R7 space");
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, "R2");

        // R4: tone switches at bit boundaries of 384 clocks
        for (int bitn = 0; bitn < 8; bitn++)
            for (int i = 0; i < 384; i++) tick(1'b0, bitn[0], "R4");

        // R4: tone switch at odd offsets inside a bit
        for (int bitn = 0; bitn < 12; bitn++)
            for (int i = 0; i < 37 + bitn * 11; i++) tick(1'b0, ~bitn[0], "R4");

        // R9: data bit changes every clock
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(1'b0, lfsr[0], "R9");
        end

        // R5: bursts of every length from 1 to 40, separated by idle clocks
        for (int len = 1; len <= 40; len++) begin
            for (int i = 0; i < len; i++) tick(1'b0, len[1], "R5 burst");
            tick(1'b1, len[0], "R5");
            tick(1'b1, ~len[0], "R2");
        end

        // R6 R7: long mixed run covering many rail landings
        for (int bitn = 0; bitn < 6; bitn++)
            for (int i = 0; i < 384; i++) tick(1'b0, (bitn % 3) != 0, "R6");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule